// File: doc/BRIEF.md
# Periodic Rollover Status and Interrupt Unit

This unit sits beside a timekeeping counter chain and records, per rate, that a counter stage has rolled over. It tracks five rates: hundredths of a second, tenths, seconds, minutes and hours. Each rate is fed by a one-cycle carry pulse from the counter chain. When a pulse arrives, the matching status bit latches, and it holds until the host reads the status. That read clears every bit.

Software uses the status bits to check a multi-byte time read. First it does a dummy status read, which arms the detector. Then it reads the counter bytes. Then it reads the status again. If the bit for the fastest counter it read is set, a carry landed during the read, and the read is repeated. A mask selects which rates may raise the interrupt. The interrupt line is high while any masked-in status bit is set.

Top module: `rollover_flag_unit`

## Requirements
- R1: Reset (rst_ni low) clears all status bits and all mask bits, and holds irq_o low. After reset is released, carries alone do not raise irq_o until a mask is written.
- R2: A pulse on carry_i[k] sets stat_o[k] on the next clock edge. The bit positions are: 0 hundredths, 1 tenths, 2 seconds, 3 minutes, 4 hours. Several pulses in one cycle set all the matching bits.
- R3: A status bit that is set stays set while no status read occurs.
- R4: A cycle with stat_rd_i high clears all status bits at the following edge. stat_o holds the value the host sees during that cycle.
- R5: A carry that arrives in the same cycle as a status read leaves its status bit set after the read.
- R6: A cycle with mask_we_i high loads mask_wdata_i into the mask, with the same bit positions as in R2. irq_o is high exactly when some status bit and its mask bit are both set.
- R7: A status bit whose mask bit is clear never raises irq_o.
- R8: Once irq_o is high, it stays high until a status read or a mask write removes the cause.
- R9: Validated read. After a dummy read, the checked bit reads zero if no carry for that rate occurred, and reads one if a carry occurred during the counter read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carry_i | input | NUM_RATES | One-cycle rollover pulses, bit positions as in R2 |
| stat_rd_i | input | 1 | Host status read strobe; clears the status after this cycle |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | NUM_RATES | New mask value |
| stat_o | output | NUM_RATES | Status bits |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to create is a carry that arrives in the very cycle a clearing read is issued. Two fixed, separate strobes cannot reach it. The bench therefore drives the read strobe and the carry together in one step, for a single rate and for a different rate. It then checks that only the coinciding bit survives. The validated-read sequence is played out as a dummy read, idle counter reads and a final read. A carry is injected in the middle of that sequence, so the retry signal is seen at the ports.

// File: rtl/rollover_flag_pkg.sv
package rollover_flag_pkg;
  localparam int unsigned NUM_RATES = 5;

  typedef enum int unsigned {
    RATE_HUNDREDTHS = 0,
    RATE_TENTHS     = 1,
    RATE_SECONDS    = 2,
    RATE_MINUTES    = 3,
    RATE_HOURS      = 4
  } rate_e;
endpackage

// File: rtl/rate_flag.sv
module rate_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over clear so a rollover during a read is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/rate_mask_reg.sv
module rate_mask_reg #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] stat_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);
  assign irq_o = |(stat_i & mask_i);
endmodule

// File: rtl/rollover_flag_unit.sv
module rollover_flag_unit
  import rollover_flag_pkg::*;
#(
  parameter int unsigned RATES = NUM_RATES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RATES-1:0] carry_i,
  input  logic             stat_rd_i,
  input  logic             mask_we_i,
  input  logic [RATES-1:0] mask_wdata_i,
  output logic [RATES-1:0] stat_o,
  output logic             irq_o
);
  logic [RATES-1:0] mask_q;

  for (genvar k = 0; k < RATES; k++) begin : g_flag
    rate_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (carry_i[k]),
      .clr_i  (stat_rd_i),
      .flag_o (stat_o[k])
    );
  end

  rate_mask_reg #(.WIDTH(RATES)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_q)
  );

  irq_merge #(.WIDTH(RATES)) u_irq (
    .stat_i (stat_o),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rollover_flag_unit_chk.sv
module rollover_flag_unit_chk #(
  parameter int unsigned RATES = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RATES-1:0] carry_i,
  input logic             stat_rd_i,
  input logic             mask_we_i,
  input logic [RATES-1:0] stat_o,
  input logic             irq_o
);
  // R1
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |=> ((stat_o == '0) && !irq_o) || !rst_ni);

  p_carry_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_i != '0) |=> ((stat_o & $past(carry_i)) == $past(carry_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R4 and R5: after a read, only the coinciding carries remain
  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (stat_o == $past(carry_i)));

  p_no_irq_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o == '0) |-> !irq_o);

  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_rd_i && !mask_we_i) |=> irq_o);
endmodule

bind rollover_flag_unit rollover_flag_unit_chk #(.RATES(RATES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .carry_i   (carry_i),
  .stat_rd_i (stat_rd_i),
  .mask_we_i (mask_we_i),
  .stat_o    (stat_o),
  .irq_o     (irq_o)
);

// File: tb/rollover_flag_unit_tb_top.sv
`timescale 1ns/100ps
module rollover_flag_unit_tb_top;
  localparam int unsigned N = 5;

  typedef struct {
    logic [N-1:0] stat;
    logic         irq;
    string        tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] carry_i = '0;
  logic         stat_rd_i = 1'b0;
  logic         mask_we_i = 1'b0;
  logic [N-1:0] mask_wdata_i = '0;
  logic [N-1:0] stat_o;
  logic         irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  exp_t q[$];
  logic [N-1:0] m_stat = '0;
  logic [N-1:0] m_mask = '0;

  always #2.5 clk_i = ~clk_i;

  rollover_flag_unit #(.RATES(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .carry_i(carry_i), .stat_rd_i(stat_rd_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .stat_o(stat_o), .irq_o(irq_o)
  );

  task automatic check(input logic [N-1:0] st, input logic iq, input string tag);
    tests++;
    if (stat_o !== st || irq_o !== iq) begin
      fails++;
      $display("FAIL %s: stat=%b irq=%b expected stat=%b irq=%b", tag, stat_o, irq_o, st, iq);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the modelled result
  task automatic step(input logic [N-1:0] c, input logic rd, input logic we,
                      input logic [N-1:0] wd, input string tag);
    exp_t e;
    @(negedge clk_i);
    carry_i = c; stat_rd_i = rd; mask_we_i = we; mask_wdata_i = wd;
    m_stat = (rd ? '0 : m_stat) | c;
    if (we) m_mask = wd;
    e.stat = m_stat; e.irq = |(m_stat & m_mask); e.tag = tag;
    q.push_back(e);
    @(posedge clk_i);
  endtask

  // monitor
  initial forever begin
    @(posedge clk_i);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.stat, e.irq, e.tag);
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check('0, 1'b0, "R1 reset state");
    @(negedge clk_i) rst_ni = 1'b1;
    step(5'b00001, 0, 0, '0, "R2 hundredths sets bit0");
    step(5'b00000, 0, 0, '0, "R3 bit held");
    step(5'b00100, 0, 0, '0, "R2 seconds sets bit2");
    step(5'b00000, 0, 0, '0, "R7 unmasked no irq");
    step(5'b00000, 0, 1, 5'b00100, "R6 mask seconds raises irq");
    step(5'b00000, 0, 1, 5'b00010, "R7 mask on clear bit");
    step(5'b00000, 0, 1, 5'b00101, "R6 mask rewrite");
    step(5'b00000, 0, 0, '0, "R8 irq held");
    step(5'b00000, 1, 0, '0, "R4 read clears");
    step(5'b01000, 0, 0, '0, "R7 minutes unmasked");
    step(5'b10000, 1, 0, '0, "R5 hours carry with read");
    step(5'b00001, 1, 0, '0, "R5 hundredths carry with read");
    step(5'b00000, 0, 0, '0, "R8 irq sticky 1");
    step(5'b00000, 0, 0, '0, "R8 irq sticky 2");
    step(5'b00000, 1, 0, '0, "R8 read drops irq");
    step(5'b11111, 0, 0, '0, "R2 all rates at once");
    step(5'b00000, 1, 0, '0, "R4 read clears all");
    // R9 validated read, no rollover
    step(5'b00000, 1, 0, '0, "R9 dummy read");
    step(5'b00000, 0, 0, '0, "R9 counter read 1");
    step(5'b00000, 0, 0, '0, "R9 counter read 2 clean");
    // R9 validated read, rollover in the middle
    step(5'b00000, 1, 0, '0, "R9 dummy read again");
    step(5'b00100, 0, 0, '0, "R9 rollover during read");
    step(5'b00000, 0, 0, '0, "R9 retry flagged");
    step(5'b00000, 0, 1, 5'b11111, "R6 mask all");
    // R1 mid-run reset clears mask and status
    @(negedge clk_i);
    carry_i = '0; stat_rd_i = 0; mask_we_i = 0;
    rst_ni = 1'b0;
    m_stat = '0; m_mask = '0;
    @(posedge clk_i); #1 check('0, 1'b0, "R1 mid-run reset");
    @(negedge clk_i) rst_ni = 1'b1;
    step(5'b11111, 0, 0, '0, "R1 mask cleared by reset");
    @(negedge clk_i);
    carry_i = '0;
    repeat (3) @(posedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule